// File: doc/BRIEF.md
# Hamming SEC-DED Codec for 8-bit Memory Words

This block guards 8-bit words held in a storage array. On the write side, a combinational encoder turns each data byte into a 13-bit stored word. That word holds a 12-position Hamming codeword plus one whole-word parity bit. On the read side, a decoder takes the stored word back. It forms a 4-bit syndrome that points straight at the failing position. It fixes any single flipped bit and marks any two flipped bits as beyond repair. It then returns the data byte together with three status flags.

The two paths are independent, so one instance can serve both ports of a memory. A parameter places an optional register stage after the decoder. The default build has this stage, which gives the read path a latency of one clock. The encoder stays combinational in every build.

Top module: `secded_protect`

## Requirements
- R1: In the stored word, bit index p-1 holds codeword position p, for p = 1 to 12. Data bits 0 to 7 sit at positions 3, 5, 6, 7, 9, 10, 11 and 12, in that order.
- R2: The check bit at position 1 is the XOR of positions 3, 5, 7, 9 and 11. Position 2 is the XOR of 3, 6, 7, 10 and 11. Position 4 is the XOR of 5, 6, 7 and 12. Position 8 is the XOR of 9, 10, 11 and 12. For example, data 8'h01 encodes to 13'h1007 and data 8'h80 encodes to 13'h1888.
- R3: Stored bit 12 makes the XOR of all 13 stored bits equal 0 (even parity).
- R4: An unaltered stored word decodes to its original data, with the error, corrected and uncorrectable flags all low.
- R5: A word with exactly one of bits 0 to 11 inverted decodes to the original data, with the error and corrected flags high and the uncorrectable flag low.
- R6: A word with only bit 12 inverted decodes to the original data, with the error and corrected flags high and the uncorrectable flag low.
- R7: A word with exactly two bits inverted raises the error and uncorrectable flags and keeps the corrected flag low. The data output then equals the data positions of the received word, unchanged.
- R8: Syndrome values 13, 14 and 15 can arise together with a failing whole-word parity, for example from three flips at positions 1, 4 and 8. Such a word is flagged as an error and uncorrectable, and its data positions pass through unchanged.
- R9: When the output register is enabled, the decoder outputs follow the input one clock later. A synchronous active-low reset clears all decoder outputs to zero.
- R10: The corrected and uncorrectable flags are never high together. The error flag is high exactly when one of the two is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the decoder output register |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_data_i | input | 8 | Data byte to encode |
| enc_cw_o | output | 13 | Stored word: positions 1..12 in bits 0..11, whole-word parity in bit 12 |
| dec_cw_i | input | 13 | Stored word read back from memory |
| dec_data_o | output | 8 | Decoded, possibly repaired, data byte |
| dec_err_o | output | 1 | Some error was seen |
| dec_corr_o | output | 1 | A single error was repaired |
| dec_uncorr_o | output | 1 | The error cannot be repaired |

## Verification
The hardest state to reach from the ports is a syndrome of 13, 14 or 15 together with a failing whole-word parity. A single flip cannot produce it and a double flip passes parity, so only an odd number of three or more flips arranged to XOR to an unused position gets there. The bench builds these words on purpose by inverting positions {1,4,8}, {2,4,8} and {1,2,12} of valid codewords. It also sweeps every single-bit position, including the parity bit alone, and mixes in seeded random double flips so that each class of error is met many times.

// File: rtl/secded_pkg.sv
// Package: shared sizing functions and position mapping for the SEC-DED codec.
// Assumes check bits occupy the power-of-two positions of a 1-based codeword.
package secded_pkg;

    localparam int DATA_W = 8;

    // Smallest number of check bits r with 2**r >= data + r + 1.
    function automatic int check_bits(input int dw);
        for (int r = 1; r < 16; r++) begin
            if ((1 << r) >= dw + r + 1) return r;
        end
        return 16;
    endfunction

    // True when a 1-based position holds a check bit.
    function automatic bit is_pow2(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // Data bit index stored at a non-power-of-two position p.
    function automatic int data_idx(input int p);
        return p - $clog2(p + 1) - 1;
    endfunction

    // 1-based codeword position of data bit d.
    function automatic int data_pos(input int d);
        int seen;
        seen = 0;
        for (int p = 1; p < 64; p++) begin
            if (!is_pow2(p)) begin
                if (seen == d) return p;
                seen++;
            end
        end
        return 0;
    endfunction

    // Decoder status carried through the output stage.
    typedef struct packed {
        logic err;
        logic corr;
        logic uncorr;
    } dec_flags_t;

endpackage

// File: rtl/secded_encoder.sv
// Encoder: spreads data over the non-power-of-two positions, fills the
// check positions and appends whole-word even parity as the top bit.
// Assumes DATA_W fits within the positions left free by the check bits.
module secded_encoder #(
    parameter int DATA_W = secded_pkg::DATA_W
) (
    input  logic [DATA_W-1:0]                              data_i,
    output logic [DATA_W+secded_pkg::check_bits(DATA_W):0] cw_o
);
    import secded_pkg::*;

    localparam int CHK_W = check_bits(DATA_W);
    localparam int CW_W  = DATA_W + CHK_W;

    logic [CW_W-1:0]  spread;  // data in place, zero at check slots
    logic [CW_W-1:0]  frame;   // full Hamming codeword
    logic [CHK_W-1:0] par;

    for (genvar p = 1; p <= CW_W; p++) begin : g_pos
        if (is_pow2(p)) begin : g_chk
            assign spread[p-1] = 1'b0;
            assign frame[p-1]  = par[$clog2(p)];
        end else begin : g_dat
            assign spread[p-1] = data_i[data_idx(p)];
            assign frame[p-1]  = spread[p-1];
        end
    end

    // Check bit k covers every position whose index has bit k set.
    always_comb begin
        par = '0;
        for (int k = 0; k < CHK_W; k++) begin
            for (int p = 1; p <= CW_W; p++) begin
                if (((p >> k) & 1) != 0) par[k] = par[k] ^ spread[p-1];
            end
        end
    end

    assign cw_o = {^frame, frame};

endmodule

// File: rtl/secded_syndrome.sv
// Syndrome unit: recomputes each check over the received codeword, including
// the stored check bit, and tests whole-word parity over all stored bits.
// Assumes the stored-word layout produced by secded_encoder.
module secded_syndrome #(
    parameter int DATA_W = secded_pkg::DATA_W
) (
    input  logic [DATA_W+secded_pkg::check_bits(DATA_W):0] cw_i,
    output logic [secded_pkg::check_bits(DATA_W)-1:0]      syn_o,
    output logic                                           par_fail_o
);
    import secded_pkg::*;

    localparam int CHK_W = check_bits(DATA_W);
    localparam int CW_W  = DATA_W + CHK_W;

    for (genvar k = 0; k < CHK_W; k++) begin : g_syn
        logic acc;
        // XOR of every position with bit k of its index set.
        always_comb begin
            acc = 1'b0;
            for (int p = 1; p <= CW_W; p++) begin
                if (((p >> k) & 1) != 0) acc = acc ^ cw_i[p-1];
            end
        end
        assign syn_o[k] = acc;
    end

    assign par_fail_o = ^cw_i;

endmodule

// File: rtl/secded_corrector.sv
// Corrector: classifies the error from syndrome and parity, flips the named
// position for a single error and extracts the data bits.
// Assumes syndrome values above CW_W cannot name a real position.
module secded_corrector #(
    parameter int DATA_W = secded_pkg::DATA_W
) (
    input  logic [DATA_W+secded_pkg::check_bits(DATA_W):0] cw_i,
    input  logic [secded_pkg::check_bits(DATA_W)-1:0]      syn_i,
    input  logic                                           par_fail_i,
    output logic [DATA_W-1:0]                              data_o,
    output secded_pkg::dec_flags_t                         flags_o
);
    import secded_pkg::*;

    localparam int CHK_W = check_bits(DATA_W);
    localparam int CW_W  = DATA_W + CHK_W;

    logic [CW_W-1:0] hit;     // one-hot decode of the syndrome
    logic [CW_W-1:0] fixed;
    logic            syn_nz;
    logic            syn_oob;
    logic            single;
    logic            uncorr;

    for (genvar p = 1; p <= CW_W; p++) begin : g_hit
        assign hit[p-1] = (int'(syn_i) == p);
    end

    // Classify: odd parity with an in-range syndrome is a single error.
    always_comb begin
        syn_nz  = (syn_i != '0);
        syn_oob = (int'(syn_i) > CW_W);
        single  = par_fail_i && syn_nz && !syn_oob;
        uncorr  = syn_nz && (!par_fail_i || syn_oob);
    end

    // Repair only on a single in-range error.
    always_comb begin
        fixed = cw_i[CW_W-1:0] ^ (single ? hit : '0);
    end

    for (genvar d = 0; d < DATA_W; d++) begin : g_ext
        assign data_o[d] = fixed[data_pos(d)-1];
    end

    // A flipped parity bit alone (zero syndrome) still counts as repaired.
    always_comb begin
        flags_o.uncorr = uncorr;
        flags_o.corr   = par_fail_i && !uncorr;
        flags_o.err    = syn_nz || par_fail_i;
    end

endmodule

// File: rtl/secded_protect.sv
// Top: SEC-DED encoder and decoder for memory words, with an optional
// register stage on the decoder outputs (synchronous active-low reset).
// Assumes the caller stores enc_cw_o unchanged and returns it on dec_cw_i.
module secded_protect #(
    parameter int DATA_W  = secded_pkg::DATA_W,
    parameter bit OUT_REG = 1'b1,
    localparam int CW_W   = DATA_W + secded_pkg::check_bits(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [CW_W:0]     enc_cw_o,
    input  logic [CW_W:0]     dec_cw_i,
    output logic [DATA_W-1:0] dec_data_o,
    output logic              dec_err_o,
    output logic              dec_corr_o,
    output logic              dec_uncorr_o
);
    import secded_pkg::*;

    localparam int CHK_W = check_bits(DATA_W);

    logic [CHK_W-1:0]  syn;
    logic              par_fail;
    logic [DATA_W-1:0] data_c;
    dec_flags_t        flags_c;

    secded_encoder #(.DATA_W(DATA_W)) u_enc (
        .data_i (enc_data_i),
        .cw_o   (enc_cw_o)
    );

    secded_syndrome #(.DATA_W(DATA_W)) u_syn (
        .cw_i       (dec_cw_i),
        .syn_o      (syn),
        .par_fail_o (par_fail)
    );

    secded_corrector #(.DATA_W(DATA_W)) u_cor (
        .cw_i       (dec_cw_i),
        .syn_i      (syn),
        .par_fail_i (par_fail),
        .data_o     (data_c),
        .flags_o    (flags_c)
    );

    if (OUT_REG) begin : g_reg
        logic [DATA_W-1:0] data_q;
        dec_flags_t        flags_q;
        // Hold decoder results for one cycle; reset clears them.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q  <= '0;
                flags_q <= '0;
            end else begin
                data_q  <= data_c;
                flags_q <= flags_c;
            end
        end
        assign dec_data_o   = data_q;
        assign dec_err_o    = flags_q.err;
        assign dec_corr_o   = flags_q.corr;
        assign dec_uncorr_o = flags_q.uncorr;
    end else begin : g_comb
        assign dec_data_o   = data_c;
        assign dec_err_o    = flags_c.err;
        assign dec_corr_o   = flags_c.corr;
        assign dec_uncorr_o = flags_c.uncorr;
    end

endmodule

// File: rtl/secded_protect_chk.sv
// Checker: port-level properties of secded_protect, bound to every instance.
// Assumes stimulus keeps enc_data_i equal to the byte whose word is decoded.
module secded_protect_chk #(
    parameter int DATA_W  = 8,
    parameter bit OUT_REG = 1'b1,
    localparam int CW_W   = DATA_W + secded_pkg::check_bits(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] enc_data_i,
    input logic [CW_W:0]     enc_cw_o,
    input logic [CW_W:0]     dec_cw_i,
    input logic [DATA_W-1:0] dec_data_o,
    input logic              dec_err_o,
    input logic              dec_corr_o,
    input logic              dec_uncorr_o
);

    p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_corr_o && dec_uncorr_o));

    p_err_summary_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err_o == (dec_corr_o || dec_uncorr_o));

    p_enc_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (^enc_cw_o) == 1'b0);

    if (OUT_REG) begin : g_seq
        p_clean_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_cw_i == enc_cw_o) |=>
            (dec_data_o == $past(enc_data_i)) && !dec_err_o);

        p_single_fix_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(dec_cw_i ^ enc_cw_o) == 1) |=>
            (dec_data_o == $past(enc_data_i)) && dec_corr_o);

        p_double_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(dec_cw_i ^ enc_cw_o) == 2) |=> dec_uncorr_o && !dec_corr_o);
    end else begin : g_cmb
        p_clean_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_cw_i == enc_cw_o) |-> (dec_data_o == enc_data_i) && !dec_err_o);

        p_single_fix_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(dec_cw_i ^ enc_cw_o) == 1) |->
            (dec_data_o == enc_data_i) && dec_corr_o);

        p_double_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(dec_cw_i ^ enc_cw_o) == 2) |-> dec_uncorr_o && !dec_corr_o);
    end

endmodule

bind secded_protect secded_protect_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enc_data_i   (enc_data_i),
    .enc_cw_o     (enc_cw_o),
    .dec_cw_i     (dec_cw_i),
    .dec_data_o   (dec_data_o),
    .dec_err_o    (dec_err_o),
    .dec_corr_o   (dec_corr_o),
    .dec_uncorr_o (dec_uncorr_o)
);

// File: tb/test_secded_protect.sv
// Bench: seeded random and directed error patterns, checked against
// reference encode/decode functions written from the requirements.
module test_secded_protect;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  enc_data_i = '0;
    logic [12:0] enc_cw_o;
    logic [12:0] dec_cw_i = '0;
    logic [7:0]  dec_data_o;
    logic        dec_err_o, dec_corr_o, dec_uncorr_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    secded_protect i_secded_protect (
        .clk          (clk),
        .rst_n        (rst_n),
        .enc_data_i   (enc_data_i),
        .enc_cw_o     (enc_cw_o),
        .dec_cw_i     (dec_cw_i),
        .dec_data_o   (dec_data_o),
        .dec_err_o    (dec_err_o),
        .dec_corr_o   (dec_corr_o),
        .dec_uncorr_o (dec_uncorr_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference encoder from R1, R2, R3.
    function automatic logic [12:0] ref_encode(input logic [7:0] d);
        logic [12:0] w;
        w = '0;
        w[2] = d[0]; w[4] = d[1]; w[5]  = d[2]; w[6]  = d[3];
        w[8] = d[4]; w[9] = d[5]; w[10] = d[6]; w[11] = d[7];
        w[0] = w[2] ^ w[4] ^ w[6] ^ w[8] ^ w[10];
        w[1] = w[2] ^ w[5] ^ w[6] ^ w[9] ^ w[10];
        w[3] = w[4] ^ w[5] ^ w[6] ^ w[11];
        w[7] = w[8] ^ w[9] ^ w[10] ^ w[11];
        w[12] = ^w[11:0];
        return w;
    endfunction

    // Reference decoder: returns {data, err, corr, uncorr} per R4..R8.
    function automatic logic [10:0] ref_decode(input logic [12:0] w);
        logic [3:0]  s;
        logic        f, c, u;
        logic [11:0] x;
        s[0] = w[0] ^ w[2] ^ w[4] ^ w[6] ^ w[8] ^ w[10];
        s[1] = w[1] ^ w[2] ^ w[5] ^ w[6] ^ w[9] ^ w[10];
        s[2] = w[3] ^ w[4] ^ w[5] ^ w[6] ^ w[11];
        s[3] = w[7] ^ w[8] ^ w[9] ^ w[10] ^ w[11];
        f = ^w;
        x = w[11:0];
        c = 1'b0;
        u = 1'b0;
        if (s == 4'd0) c = f;
        else if (f && s <= 4'd12) begin
            x[s-4'd1] = ~x[s-4'd1];
            c = 1'b1;
        end else u = 1'b1;
        return {x[11], x[10], x[9], x[8], x[6], x[5], x[4], x[2], c | u, c, u};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply one byte and an error mask, then check encoder and decoder.
    task automatic run_case(input logic [7:0] d, input logic [12:0] mask, input string req);
        logic [10:0] exp;
        @(negedge clk);
        enc_data_i = d;
        dec_cw_i   = ref_encode(d) ^ mask;
        exp        = ref_decode(dec_cw_i);
        #1;
        chk("R2 encoder word", 32'(enc_cw_o), 32'(ref_encode(d)));
        @(negedge clk);
        chk({req, " data"}, 32'(dec_data_o), 32'(exp[10:3]));
        chk({req, " flags"}, 32'({dec_err_o, dec_corr_o, dec_uncorr_o}), 32'(exp[2:0]));
        if ($countones(mask) <= 1)
            chk({req, " data vs original"}, 32'(dec_data_o), 32'(d));
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_fails++;
            $display("FAIL R9 watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [7:0]  d;
        logic [12:0] m;
        int          a, b, n;
        void'($urandom(32'd7741));

        // R9: reset clears outputs even with an uncorrectable word applied.
        enc_data_i = 8'h3C;
        dec_cw_i   = ref_encode(8'h3C) ^ 13'h0011;
        repeat (3) @(negedge clk);
        chk("R9 reset data", 32'(dec_data_o), 32'h0);
        chk("R9 reset flags", 32'({dec_err_o, dec_corr_o, dec_uncorr_o}), 32'h0);
        rst_n = 1'b1;

        // R1, R2, R3: literal encodings.
        @(negedge clk);
        enc_data_i = 8'h01; dec_cw_i = 13'h1007;
        #1 chk("R1 R2 encode 01", 32'(enc_cw_o), 32'h1007);
        @(negedge clk);
        enc_data_i = 8'h80; dec_cw_i = 13'h1888;
        #1 chk("R1 R2 encode 80", 32'(enc_cw_o), 32'h1888);
        chk("R3 even parity", 32'(^enc_cw_o), 32'h0);

        // R9: output holds until the next edge, then follows.
        @(negedge clk);
        chk("R9 settled", 32'(dec_data_o), 32'h80);
        enc_data_i = 8'h5A; dec_cw_i = ref_encode(8'h5A);
        #1 chk("R9 before edge", 32'(dec_data_o), 32'h80);
        @(negedge clk);
        chk("R9 after edge", 32'(dec_data_o), 32'h5A);

        // R4 clean words, R5 every single position, R6 parity bit alone.
        run_case(8'h00, 13'h0, "R4 clean");
        run_case(8'hFF, 13'h0, "R4 clean");
        for (int p = 0; p < 12; p++) run_case(8'hA5, 13'(1) << p, "R5 single");
        run_case(8'hA5, 13'h1000, "R6 parity bit");
        run_case(8'h3C, 13'h1000, "R6 parity bit");

        // R7 doubles, R8 triples that name positions 13, 14, 15.
        run_case(8'hC3, 13'h0003, "R7 double");
        run_case(8'hC3, 13'h1800, "R7 double");
        run_case(8'h96, 13'h0089, "R8 syndrome 13");
        run_case(8'h96, 13'h008A, "R8 syndrome 14");
        run_case(8'h69, 13'h0803, "R8 syndrome 15");

        // Seeded random mix of 0, 1 and 2 flips (R4, R5, R6, R7, R10).
        for (int i = 0; i < 400; i++) begin
            d = 8'($urandom);
            n = $urandom_range(0, 2);
            a = $urandom_range(0, 12);
            b = (a + 1 + $urandom_range(0, 11)) % 13;
            m = '0;
            if (n >= 1) m[a] = 1'b1;
            if (n == 2) m[b] = 1'b1;
            run_case(d, m, "R10 random");
            chk("R10 exclusive", 32'(dec_corr_o & dec_uncorr_o), 32'h0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule